// File: doc/BRIEF.md
# Serial Slave Address Match Unit

This block is the byte engine of a serial channel that may sit on a two-wire or shared bidirectional bus. A host-side write to the data register loads a byte and, if the channel is enabled, starts a transfer. The byte is then clocked out most significant bit first while the incoming line is shifted in, all paced by an external serial clock. The serial clock is brought into the system clock domain by a synchronizer and edge detector. After eight serial clocks the received byte is available and a one-cycle completion pulse is produced.

When the byte in flight is marked as an address byte, the received value is compared with a programmable slave address. The lowest bit can optionally be left out of the compare. A match sets a coincidence flag. A mismatch clears a bus-release flag, which an external stop detector sets. The interrupt has three modes. It can fire on every completed byte. In wake-up mode it fires only on a matching address. It can also fire only on bus-release events, and this setting takes priority over wake-up. A busy flag can be raised at the end of each byte, and the next data write drops it.

Top module: `saddr_match_unit`

## Requirements
- R1: After reset, sdo is 1 and coi, rel_flag, busy, irq and xfer_done are all 0.
- R2: A pulse on wr_data with chan_en at 1 loads wr_byte and starts a transfer. With chan_en at 0 the write starts nothing: xfer_done does not pulse, rx_byte keeps its value and sdo stays unchanged under serial clocks.
- R3: Before the k-th rising sck edge (k = 0..7), sdo equals bit 7-k of the written byte. sdo changes only after a falling sck edge. sdi is sampled on each rising edge and shifted in at bit 0. After the 8th rising edge, rx_byte holds the eight received bits with the first one at bit 7, and xfer_done pulses for exactly one cycle.
- R4: A byte of 0xFF written before a reception keeps sdo at 1 for the whole transfer.
- R5: When an address byte (addr_byte = 1 at the write) completes and rx_byte equals slave_addr on all 8 bits, coi becomes 1. Starting a new address transfer clears coi to 0. Data-byte transfers leave coi unchanged.
- R6: With mask_lsb = 1, the address compare uses only bits 7..1, so a received byte that differs from slave_addr only in bit 0 still sets coi.
- R7: A bus_release pulse sets rel_flag to 1. A completed address byte that does not match clears rel_flag to 0.
- R8: With wake_en = 0 and rel_irq_sel = 0, irq pulses once for every completed transfer.
- R9: With wake_en = 1 and rel_irq_sel = 0, irq pulses only for a completed address byte that matches. Data bytes and mismatching addresses raise no irq.
- R10: With rel_irq_sel = 1, completed transfers raise no irq, whatever the state of wake_en. Each bus_release pulse raises one irq instead.
- R11: With busy_en = 1, busy becomes 1 when a transfer completes. Any wr_data pulse clears busy in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; a write starts a transfer only when 1 |
| wr_data | input | 1 | One-cycle write strobe for the data register |
| wr_byte | input | 8 | Byte to load and transmit |
| addr_byte | input | 1 | Marks the byte being started as an address byte |
| slave_addr | input | 8 | Own slave address |
| mask_lsb | input | 1 | Ignore bit 0 in the address compare |
| wake_en | input | 1 | Interrupt only on an address match |
| rel_irq_sel | input | 1 | Interrupt on bus release instead of byte completion |
| busy_en | input | 1 | Raise busy at the end of each byte |
| bus_release | input | 1 | One-cycle pulse from the stop detector |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rx_byte | output | 8 | Shift register contents |
| xfer_done | output | 1 | One-cycle pulse at the end of a byte |
| coi | output | 1 | Address coincidence flag |
| rel_flag | output | 1 | Bus-release flag |
| busy | output | 1 | Busy flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong bit counter or shift register appears at the ports within one serial clock. It shows up as a wrong sdo bit before the next rising edge, as a missing or extra xfer_done pulse, or as a rotated rx_byte once the byte ends. A wrong address flag or a wrong compare shows up one system clock after xfer_done, in coi, rel_flag and irq. Because of this, every transfer is followed by checks of those three outputs and of the number of irq pulses it produced. A wrong mode priority shows up only when wake-up and release selection are both set, so that case is checked with its own transfer and release pulse.

// File: rtl/saddr_pkg.sv
package saddr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t            sr;
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             sdo;
        logic             done;
    } shift_st_t;

    typedef struct packed {
        logic addr;
        logic coi;
        logic rel;
        logic busy;
        logic irq;
    } match_st_t;

    function automatic logic addr_hit(byte_t rx, byte_t own, logic mask);
        logic hit;
        if (mask) hit = (rx[BYTE_W-1:1] == own[BYTE_W-1:1]);
        else      hit = (rx == own);
        return hit;
    endfunction
endpackage

// File: rtl/saddr_edge_det.sv
module saddr_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], sck_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.sync[STAGES-1] & st_q.prev;
endmodule

// File: rtl/saddr_shift_core.sv
module saddr_shift_core
    import saddr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  byte_t load_data_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  sdi_i,
    output logic  sdo_o,
    output byte_t data_o,
    output logic  done_o
);
    shift_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load_i) begin
            st_d.sr     = load_data_i;
            st_d.cnt    = '0;
            st_d.active = 1'b1;
            st_d.sdo    = load_data_i[BYTE_W-1];
        end else if (st_q.active) begin
            if (rise_i) begin
                st_d.sr = {st_q.sr[BYTE_W-2:0], sdi_i};
                if (st_q.cnt == CNT_W'(BYTE_W-1)) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (fall_i) begin
                st_d.sdo = st_q.sr[BYTE_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sdo <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o  = st_q.sdo;
    assign data_o = st_q.sr;
    assign done_o = st_q.done;
endmodule

// File: rtl/saddr_match_ctrl.sv
module saddr_match_ctrl
    import saddr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  wr_i,
    input  logic  addr_byte_i,
    input  logic  done_i,
    input  byte_t rx_i,
    input  byte_t own_addr_i,
    input  logic  mask_lsb_i,
    input  logic  wake_en_i,
    input  logic  rel_sel_i,
    input  logic  busy_en_i,
    input  logic  release_i,
    output logic  coi_o,
    output logic  rel_o,
    output logic  busy_o,
    output logic  irq_o
);
    match_st_t st_d, st_q;
    logic      hit;

    assign hit = addr_hit(rx_i, own_addr_i, mask_lsb_i);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start_i) begin
            st_d.addr = addr_byte_i;
            if (addr_byte_i) st_d.coi = 1'b0;
        end
        if (done_i) begin
            if (st_q.addr) begin
                if (hit) st_d.coi = 1'b1;
                else     st_d.rel = 1'b0;
            end
            if (busy_en_i) st_d.busy = 1'b1;
            if (!rel_sel_i && (!wake_en_i || (st_q.addr && hit)))
                st_d.irq = 1'b1;
        end
        if (release_i) begin
            st_d.rel = 1'b1;
            if (rel_sel_i) st_d.irq = 1'b1;
        end
        if (wr_i) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coi_o  = st_q.coi;
    assign rel_o  = st_q.rel;
    assign busy_o = st_q.busy;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/saddr_match_unit.sv
module saddr_match_unit
    import saddr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_en,
    input  logic        wr_data,
    input  logic [7:0]  wr_byte,
    input  logic        addr_byte,
    input  logic [7:0]  slave_addr,
    input  logic        mask_lsb,
    input  logic        wake_en,
    input  logic        rel_irq_sel,
    input  logic        busy_en,
    input  logic        bus_release,
    input  logic        sck,
    input  logic        sdi,
    output logic        sdo,
    output logic [7:0]  rx_byte,
    output logic        xfer_done,
    output logic        coi,
    output logic        rel_flag,
    output logic        busy,
    output logic        irq
);
    logic sck_rise, sck_fall, start;

    assign start = wr_data & chan_en;

    saddr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    saddr_shift_core u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start),
        .load_data_i (wr_byte),
        .rise_i      (sck_rise),
        .fall_i      (sck_fall),
        .sdi_i       (sdi),
        .sdo_o       (sdo),
        .data_o      (rx_byte),
        .done_o      (xfer_done)
    );

    saddr_match_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .wr_i        (wr_data),
        .addr_byte_i (addr_byte),
        .done_i      (xfer_done),
        .rx_i        (rx_byte),
        .own_addr_i  (slave_addr),
        .mask_lsb_i  (mask_lsb),
        .wake_en_i   (wake_en),
        .rel_sel_i   (rel_irq_sel),
        .busy_en_i   (busy_en),
        .release_i   (bus_release),
        .coi_o       (coi),
        .rel_o       (rel_flag),
        .busy_o      (busy),
        .irq_o       (irq)
    );
endmodule

// File: rtl/saddr_match_checker.sv
module saddr_match_checker (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic wr_data,
    input logic addr_byte,
    input logic wake_en,
    input logic rel_irq_sel,
    input logic bus_release,
    input logic xfer_done,
    input logic coi,
    input logic busy,
    input logic irq
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R3

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(xfer_done) || $past(bus_release))); // R8

    AST_WAKE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(wake_en && !rel_irq_sel)) |-> coi); // R9

    AST_REL_SEL_ONLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rel_irq_sel)) |-> $past(bus_release)); // R10

    AST_WRITE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !busy); // R11

    AST_ADDR_START_CLEARS_COI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && chan_en && addr_byte && !xfer_done) |=> !coi); // R5
endmodule

bind saddr_match_unit saddr_match_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .wr_data     (wr_data),
    .addr_byte   (addr_byte),
    .wake_en     (wake_en),
    .rel_irq_sel (rel_irq_sel),
    .bus_release (bus_release),
    .xfer_done   (xfer_done),
    .coi         (coi),
    .busy        (busy),
    .irq         (irq)
);

// File: tb/tb_saddr_match_unit.sv
`timescale 1ns/1ps
module tb_saddr_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0, wr_data = 1'b0, addr_byte = 1'b0;
    logic [7:0] wr_byte = '0, slave_addr = '0;
    logic       mask_lsb = 1'b0, wake_en = 1'b0, rel_irq_sel = 1'b0, busy_en = 1'b0;
    logic       bus_release = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic       sdo, xfer_done, coi, rel_flag, busy, irq;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;
    int n_irq  = 0;
    int n_done = 0;

    always #10 clk = ~clk;

    saddr_match_unit dut (.*);

    always @(posedge clk) begin
        if (irq)       n_irq  <= n_irq + 1;
        if (xfer_done) n_done <= n_done + 1;
    end

    typedef struct packed {
        logic       ab;
        logic       wk;
        logic       mk;
        logic [7:0] sva;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       ecoi;
        logic [1:0] eirq;
        logic       erel;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h3C, 1'b0, 2'd1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h52, 8'hFF, 8'h52, 1'b1, 2'd1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'h52, 8'hFF, 8'h53, 1'b0, 2'd0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h52, 8'hFF, 8'h53, 1'b1, 2'd1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h52, 8'h00, 8'h13, 1'b0, 2'd1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h52, 8'hC3, 8'h52, 1'b0, 2'd0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'hA0, 8'hFF, 8'hA0, 1'b1, 2'd1, 1'b1},
        '{1'b0, 1'b0, 1'b0, 8'hA0, 8'h5A, 8'h0F, 1'b1, 2'd1, 1'b1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_release();
        bus_release = 1'b1;
        cyc(1);
        bus_release = 1'b0;
        cyc(2);
    endtask

    // write a byte, then run 8 serial clocks; sdo compared with exp_sdo bits
    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] rx,
                            input logic [7:0] exp_sdo, output logic sdo_ok);
        sdo_ok  = 1'b1;
        wr_byte = tx;
        wr_data = 1'b1;
        cyc(1);
        wr_data = 1'b0;
        cyc(2);
        for (int i = 0; i < 8; i++) begin
            sdi = rx[7-i];
            cyc(8);
            if (sdo !== exp_sdo[7-i]) sdo_ok = 1'b0;
            sck = 1'b1;
            cyc(8);
            sck = 1'b0;
        end
        cyc(10);
    endtask

    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ok;
        logic [7:0] held;
        int base;
        cyc(3);
        // R1 reset state
        check(sdo === 1'b1, "R1 sdo", sdo, 1);
        check({coi, rel_flag, busy, irq, xfer_done} === 5'b0, "R1 flags",
              {coi, rel_flag, busy, irq, xfer_done}, 0);
        rst_n = 1'b1;
        cyc(2);
        chan_en = 1'b1;

        foreach (VECS[k]) begin
            addr_byte  = VECS[k].ab;
            wake_en    = VECS[k].wk;
            mask_lsb   = VECS[k].mk;
            slave_addr = VECS[k].sva;
            pulse_release();
            n_irq  = 0;
            n_done = 0;
            run_xfer(VECS[k].tx, VECS[k].rx, VECS[k].tx, ok);
            check(ok, "R3/R4 sdo bit order", k, 1);
            check(rx_byte === VECS[k].rx, "R3 rx_byte", rx_byte, VECS[k].rx);
            check(n_done == 1, "R3 done pulses", n_done, 1);
            check(coi === VECS[k].ecoi, "R5/R6 coi", coi, VECS[k].ecoi);
            check(rel_flag === VECS[k].erel, "R7 rel_flag", rel_flag, VECS[k].erel);
            check(n_irq == int'(VECS[k].eirq), "R8/R9 irq count", n_irq, VECS[k].eirq);
        end

        // R2: disabled write starts nothing
        chan_en   = 1'b0;
        addr_byte = 1'b0;
        wake_en   = 1'b0;
        held      = rx_byte;
        n_done    = 0;
        n_irq     = 0;
        run_xfer(8'h00, 8'hAA, {8{sdo}}, ok);
        check(n_done == 0, "R2 no done when disabled", n_done, 0);
        check(rx_byte === held, "R2 rx_byte kept", rx_byte, held);
        check(ok, "R2 sdo unchanged", 0, 1);
        check(n_irq == 0, "R2 no irq", n_irq, 0);

        // R10: release select overrides wake-up
        chan_en     = 1'b1;
        addr_byte   = 1'b1;
        wake_en     = 1'b1;
        rel_irq_sel = 1'b1;
        slave_addr  = 8'h3E;
        n_irq       = 0;
        run_xfer(8'hFF, 8'h3E, 8'hFF, ok);
        check(coi === 1'b1, "R10 match seen", coi, 1);
        check(n_irq == 0, "R10 no irq on transfer", n_irq, 0);
        pulse_release();
        check(n_irq == 1, "R10 irq on release", n_irq, 1);
        check(rel_flag === 1'b1, "R7 release sets flag", rel_flag, 1);

        // R11: busy set at done, cleared by write
        rel_irq_sel = 1'b0;
        wake_en     = 1'b0;
        addr_byte   = 1'b0;
        busy_en     = 1'b1;
        base        = n_done;
        run_xfer(8'h81, 8'h18, 8'h81, ok);
        check(n_done == base + 1, "R11 transfer done", n_done, base + 1);
        check(busy === 1'b1, "R11 busy set", busy, 1);
        chan_en = 1'b0;
        wr_data = 1'b1;
        cyc(1);
        wr_data = 1'b0;
        check(busy === 1'b0, "R11 busy cleared by write", busy, 0);
        check(busy_en === 1'b1, "R11 busy enable kept", busy_en, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule